// File: doc/BRIEF.md
# Manual-Trigger Comma Word Aligner

This block sits behind a 10-bit deserializer whose word boundary is arbitrary. It joins the previous and the current raw word into a 20-bit window and tests ten bit offsets of that window against an alignment pattern. Either running-disparity form of the pattern counts as a match. The comparison covers either all ten bits or only the seven most significant bits of each candidate.

A search begins only when software raises the trigger input; a level held high does nothing more. The first match during a search fixes the bit offset. The block then pulses a detect flag, sets its locked status and stops searching. After that it rotates every incoming word by the stored offset and ignores any later pattern occurrences. A new rising trigger edge drops the lock and starts a fresh search. Reset leaves the block idle and unlocked, and no search runs until the first trigger edge.

Top module: `comma_aligner`

## Requirements
- R1: After reset, patDetect, locked, alignedValid and alignedWord are all 0. The block does not lock on any pattern until the first rising edge of alignReq.
- R2: A rising edge of alignReq, sampled at a clock edge, clears locked at that edge and starts a search. Holding alignReq high does not start another search.
- R3: The search window is {previous rawWord, current rawWord}, with the previous word in bits 19:10. The candidate at offset k (0..9) is window bits [19-k : 10-k]. When several offsets match, the lowest k wins.
- R4: A candidate matches if it equals either PAT_POS or PAT_NEG under the active compare mask.
- R5: With patMode = 0, all 10 candidate bits are compared. With patMode = 1, only candidate bits 9:3 are compared against pattern bits 9:3.
- R6: At the clock edge where a search is active and the window matches, patDetect is 1 and locked is 1 after that edge. patDetect is 0 again one edge later.
- R7: While locked, the stored offset does not change and further pattern occurrences give no patDetect. This holds until the next trigger edge.
- R8: At each edge, alignedValid takes the locked value from before that edge. When it is 1, alignedWord is the candidate at the stored offset of the window presented at that edge. When alignedValid is 0, alignedWord is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rstN | input | 1 | Active-low synchronous reset |
| rawWord | input | 10 | Unaligned word from the deserializer, bit 9 received first |
| patMode | input | 1 | 0: compare 10 bits, 1: compare upper 7 bits |
| alignReq | input | 1 | Search trigger, acting on its rising edge |
| alignedWord | output | 10 | Word rotated by the locked offset |
| alignedValid | output | 1 | alignedWord carries aligned data |
| patDetect | output | 1 | One-cycle pulse when the pattern is found |
| locked | output | 1 | Offset is fixed |

## Verification
Most internal faults show up in the cycle after they happen. A wrong stored offset is visible at alignedWord on the first valid word after the lock. It stays visible on every word after that, because the offset is never reloaded. A search flag that is set or cleared wrongly shows up as a lock without a trigger, a missing lock, or a re-lock during a locked period. Each of these appears at patDetect and locked one edge after the window that caused it. A faulty rising-edge detector is seen when the trigger is held high across a later pattern. A faulty compare mask is seen when a 7-bit-only match is presented in 10-bit mode.

// File: rtl/calign_pkg.sv
package calign_pkg;
  typedef struct packed {
    logic loadOffset;
    logic clearLock;
    logic locked;
  } alignCtl_t;
endpackage

// File: rtl/calign_datapath.sv
module calign_datapath
  import calign_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int SHORT_W = 7,
  parameter logic [WORD_W-1:0] PAT_POS = 10'b0011111010,
  parameter logic [WORD_W-1:0] PAT_NEG = 10'b1100000101
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] rawWord,
  input  logic              patMode,
  input  alignCtl_t         ctl,
  output logic              hitAny,
  output logic [WORD_W-1:0] wordOut,
  output logic              validOut
);
  localparam int WIN_W = 2 * WORD_W;
  localparam int OFF_W = $clog2(WORD_W);
  localparam logic [WORD_W-1:0] SHORT_MASK = {{SHORT_W{1'b1}}, {(WORD_W-SHORT_W){1'b0}}};

  logic [WORD_W-1:0] prevQ;
  logic [WIN_W-1:0]  window;
  logic [WORD_W-1:0] cand [WORD_W];
  logic [WORD_W-1:0] hit;
  logic [WORD_W-1:0] cmpMask;
  logic [OFF_W-1:0]  hitIdx;
  logic [OFF_W-1:0]  offsetQ;
  logic [WORD_W-1:0] wordQ;
  logic              validQ;

  assign window  = {prevQ, rawWord};
  assign cmpMask = patMode ? SHORT_MASK : '1;

  for (genvar g = 0; g < WORD_W; g++) begin : gCand
    assign cand[g] = window[WIN_W-1-g -: WORD_W];
    assign hit[g]  = (((cand[g] ^ PAT_POS) & cmpMask) == '0) ||
                     (((cand[g] ^ PAT_NEG) & cmpMask) == '0);
  end

  assign hitAny = |hit;

  always_comb begin
    hitIdx = '0;
    for (int k = WORD_W - 1; k >= 0; k--) begin
      if (hit[k]) hitIdx = OFF_W'(k);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevQ   <= '0;
      offsetQ <= '0;
      wordQ   <= '0;
      validQ  <= 1'b0;
    end else begin
      prevQ <= rawWord;
      if (ctl.loadOffset) offsetQ <= hitIdx;
      validQ <= ctl.locked;
      wordQ  <= ctl.locked ? cand[offsetQ] : '0;
    end
  end

  assign wordOut  = wordQ;
  assign validOut = validQ;

  AST_OFFSET_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.locked && !ctl.loadOffset |=> $stable(offsetQ)); // R7
  AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !validQ |-> wordQ == '0); // R8
  AST_VALID_FOLLOWS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    ctl.locked |=> validQ); // R8
endmodule

// File: rtl/calign_control.sv
module calign_control
  import calign_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      alignReq,
  input  logic      hitAny,
  output alignCtl_t ctl,
  output logic      detectOut,
  output logic      lockedOut
);
  logic reqQ;
  logic searchQ;
  logic lockQ;
  logic detQ;
  logic reqRise;

  assign reqRise = alignReq & ~reqQ;

  assign ctl.clearLock  = reqRise;
  assign ctl.loadOffset = searchQ & hitAny & ~reqRise;
  assign ctl.locked     = lockQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqQ    <= 1'b0;
      searchQ <= 1'b0;
      lockQ   <= 1'b0;
      detQ    <= 1'b0;
    end else begin
      reqQ <= alignReq;
      if (ctl.clearLock) begin
        searchQ <= 1'b1;
        lockQ   <= 1'b0;
        detQ    <= 1'b0;
      end else if (ctl.loadOffset) begin
        searchQ <= 1'b0;
        lockQ   <= 1'b1;
        detQ    <= 1'b1;
      end else begin
        detQ <= 1'b0;
      end
    end
  end

  assign detectOut = detQ;
  assign lockedOut = lockQ;

  AST_DETECT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    detQ |=> !detQ); // R6
  AST_DETECT_LOCKS: assert property (@(posedge clk) disable iff (!rstN)
    detQ |-> lockQ); // R6
  AST_RISE_UNLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    reqRise |=> !lockQ && searchQ); // R2
  AST_LOCK_NEEDS_SEARCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockQ) |-> $past(searchQ)); // R1
  AST_NO_SEARCH_WHILE_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    !(searchQ && lockQ)); // R7
endmodule

// File: rtl/comma_aligner.sv
module comma_aligner
  import calign_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int SHORT_W = 7,
  parameter logic [WORD_W-1:0] PAT_POS = 10'b0011111010,
  parameter logic [WORD_W-1:0] PAT_NEG = 10'b1100000101
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] rawWord,
  input  logic              patMode,
  input  logic              alignReq,
  output logic [WORD_W-1:0] alignedWord,
  output logic              alignedValid,
  output logic              patDetect,
  output logic              locked
);
  alignCtl_t ctl;
  logic      hitAny;

  calign_control uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .alignReq  (alignReq),
    .hitAny    (hitAny),
    .ctl       (ctl),
    .detectOut (patDetect),
    .lockedOut (locked)
  );

  calign_datapath #(
    .WORD_W  (WORD_W),
    .SHORT_W (SHORT_W),
    .PAT_POS (PAT_POS),
    .PAT_NEG (PAT_NEG)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .rawWord  (rawWord),
    .patMode  (patMode),
    .ctl      (ctl),
    .hitAny   (hitAny),
    .wordOut  (alignedWord),
    .validOut (alignedValid)
  );
endmodule

// File: tb/tb_comma_aligner.sv
module tb_comma_aligner;
  localparam logic [9:0] POS = 10'b0011111010;
  localparam logic [9:0] NEG = 10'b1100000101;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] rawWord = '0;
  logic       patMode = 1'b0;
  logic       alignReq = 1'b0;
  logic [9:0] alignedWord;
  logic       alignedValid, patDetect, locked;

  comma_aligner dut (
    .clk(clk), .rstN(rstN), .rawWord(rawWord), .patMode(patMode),
    .alignReq(alignReq), .alignedWord(alignedWord),
    .alignedValid(alignedValid), .patDetect(patDetect), .locked(locked)
  );

  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  // reference state
  logic [9:0] mPrev = '0, mData = '0;
  logic       mReq = 0, mSearch = 0, mLock = 0, mDet = 0, mValid = 0;
  int         mOff = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] cand(input logic [9:0] p, input logic [9:0] c, input int k);
    logic [19:0] w;
    w = {p, c};
    return w[19-k -: 10];
  endfunction

  function automatic bit isMatch(input logic [9:0] v, input bit md);
    logic [9:0] m;
    m = md ? 10'b1111111000 : 10'b1111111111;
    return (((v ^ POS) & m) == 0) || (((v ^ NEG) & m) == 0);
  endfunction

  function automatic int firstHit(input logic [9:0] p, input logic [9:0] c, input bit md);
    for (int k = 0; k < 10; k++) if (isMatch(cand(p, c, k), md)) return k;
    return -1;
  endfunction

  task automatic step(input logic [9:0] w, input logic rq, input logic md);
    logic       nValid;
    logic [9:0] nData;
    int         idx;
    @(negedge clk);
    check(patDetect == mDet, "R6 detect", 32'(patDetect), 32'(mDet));
    check(locked == mLock, "R2 locked", 32'(locked), 32'(mLock));
    check(alignedValid == mValid, "R8 valid", 32'(alignedValid), 32'(mValid));
    check(alignedWord == mData, "R8 data", 32'(alignedWord), 32'(mData));
    rawWord = w; alignReq = rq; patMode = md;
    nValid = mLock;
    nData  = mLock ? cand(mPrev, w, mOff) : 10'd0;
    idx    = firstHit(mPrev, w, md);
    if (rq && !mReq) begin
      mSearch = 1; mLock = 0; mDet = 0;
    end else if (mSearch && idx >= 0) begin
      mSearch = 0; mLock = 1; mOff = idx; mDet = 1;
    end else begin
      mDet = 0;
    end
    mValid = nValid; mData = nData; mPrev = w; mReq = rq;
  endtask

  // place pattern at offset k across two words, given filler
  task automatic sendPat(input int k, input logic [9:0] pat, input logic rq, input logic md,
                         input logic [19:0] fill);
    logic [19:0] w;
    w = fill;
    w[19-k -: 10] = pat;
    step(w[19:10], rq, md);
    step(w[9:0], rq, md);
  endtask

  task automatic afterEdge();
    @(posedge clk); #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [9:0] a, b, secondWord;
    logic [19:0] w;
    int unused;
    unused = $urandom(32'd4242);

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check(locked == 0 && patDetect == 0, "R1 reset flags", {30'd0, locked, patDetect}, 0);
    check(alignedValid == 0 && alignedWord == 0, "R1 reset data", 32'(alignedWord), 0);
    @(negedge clk); rstN = 1;

    // R1: pattern without trigger gives no lock
    sendPat(4, POS, 0, 0, 20'd0);
    step(10'd0, 0, 0);
    afterEdge();
    check(locked == 0, "R1 no search before trigger", 32'(locked), 0);

    // R6: trigger then pattern at offset 6
    step(10'd0, 1, 0);
    w = 20'd0; w[13 -: 10] = POS; secondWord = w[9:0];
    sendPat(6, POS, 1, 0, 20'd0);
    afterEdge();
    check(patDetect == 1 && locked == 1, "R6 detect on match", {30'd0, patDetect, locked}, 3);
    a = 10'h2A5;
    step(a, 1, 0);
    afterEdge();
    check(patDetect == 0, "R6 pulse one cycle", 32'(patDetect), 0);
    check(alignedValid == 1 && alignedWord == cand(secondWord, a, 6), "R8 first aligned word",
          32'(alignedWord), 32'(cand(secondWord, a, 6)));

    // R7 and R2: held trigger plus new pattern at other offset
    sendPat(2, NEG, 1, 0, 20'd0);
    afterEdge();
    check(locked == 1 && patDetect == 0, "R7 no relock", {30'd0, locked, patDetect}, 2);
    a = 10'h13C; b = 10'h3C1;
    step(a, 1, 0); step(b, 1, 0);
    afterEdge();
    check(alignedWord == cand(a, b, 6), "R7 offset kept", 32'(alignedWord), 32'(cand(a, b, 6)));

    // R2: fresh edge clears lock
    step(10'd0, 0, 0);
    step(10'd0, 1, 0);
    afterEdge();
    check(locked == 0, "R2 edge clears lock", 32'(locked), 0);

    // R4: negative form at offset 9
    sendPat(9, NEG, 1, 0, 20'd0);
    afterEdge();
    check(locked == 1, "R4 negative pattern locks", 32'(locked), 1);
    a = 10'h0F3; b = 10'h355;
    step(a, 1, 0); step(b, 1, 0);
    afterEdge();
    check(alignedWord == cand(a, b, 9), "R4 offset 9 data", 32'(alignedWord), 32'(cand(a, b, 9)));

    // R5: 7-bit-only match ignored in 10-bit mode
    step(10'd0, 0, 0);
    step(10'd0, 1, 0);
    sendPat(5, POS ^ 10'b0000000111, 1, 0, 20'd0);
    afterEdge();
    check(locked == 0, "R5 full compare rejects partial", 32'(locked), 0);

    // R3/R5: two 7-bit hits, offsets 1 and 9, lowest wins
    w = 20'd0;
    w[18 -: 7] = POS[9:3];
    w[10 -: 7] = POS[9:3];
    step(w[19:10], 1, 1); step(w[9:0], 1, 1);
    afterEdge();
    check(locked == 1, "R5 short compare locks", 32'(locked), 1);
    a = 10'h1E7; b = 10'h0B9;
    step(a, 1, 1); step(b, 1, 1);
    afterEdge();
    check(alignedWord == cand(a, b, 1), "R3 lowest offset wins", 32'(alignedWord), 32'(cand(a, b, 1)));

    // random phase
    for (int i = 0; i < 600; i++) begin
      logic rq, md;
      rq = ($urandom % 20) == 0 ? ~mReq : mReq;
      md = ($urandom % 50) == 0 ? ~patMode : patMode;
      if (($urandom % 8) == 0)
        sendPat(int'($urandom % 10), ($urandom % 2) ? POS : NEG, rq, md, 20'($urandom));
      else
        step(10'($urandom), rq, md);
    end
    step(10'd0, mReq, patMode);
    step(10'd0, mReq, patMode);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule